// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned or two's-complement operands with a carry-in. It returns the sum, the carry-out and a signed-overflow flag. It is purely combinational. No carry ripples from bit to bit or from group to group. Each bit cell forms its sum along with a propagate term (the XOR of the operand bits) and a generate term (the AND of the operand bits). The bits are split into groups of `GRP_W`.

Each group has a lookahead unit. From the group carry-in it derives every carry inside the group as a flat sum of products, and it also exports a group propagate and a group generate. A second lookahead unit of the same design takes the group propagate and generate pairs and the external carry-in. From them it derives the carry into every group and the final carry-out. The operand width is `GRP_W * GRP_W`, which is 16 bits with the default `GRP_W = 4`.

The flag `ovf_o` reports signed overflow. It is set when the carry into the top bit differs from the carry out of it. It is meant for datapaths that need an adder with a short carry path and no registers.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals `(a_i + b_i + cin_i) mod 2^16` for every input combination.
- R2: `cout_o` equals bit 16 of the 17-bit result of `a_i + b_i + cin_i`.
- R3: `ovf_o` is 1 exactly when `a_i[15]` equals `b_i[15]` and `sum_o[15]` differs from them. It is never 1 when the two operand sign bits differ.
- R4: When `a_i` is the bitwise inverse of `b_i` (every bit propagates), `sum_o` is 0xFFFF with `cout_o` 0 for `cin_i` 0, and `sum_o` is 0x0000 with `cout_o` 1 for `cin_i` 1.
- R5: 0xFFFF + 0x0001 with `cin_i` 0 gives `sum_o` 0x0000, `cout_o` 1 and `ovf_o` 0. 0x7FFF + 0x0001 gives `sum_o` 0x8000, `cout_o` 0 and `ovf_o` 1.
- R6: With both operands zero, `sum_o` equals `cin_i`, and `cout_o` and `ovf_o` are 0.
- R7: Swapping `a_i` and `b_i` leaves `sum_o`, `cout_o` and `ovf_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum modulo 2^16 |
| cout_o | output | 1 | Carry out of bit 15 |
| ovf_o | output | 1 | Two's-complement overflow |

## Verification
Carry-out and signed overflow can both be asserted for the same input vector. This happens when both operands are negative and the sum wraps to a non-negative value, for example 0x8000 + 0x8000, which gives a zero sum with both flags set. The bench drives such vectors directly, and random vectors also hit them often. The two flags are judged independently: the carry against bit 16 of a wide behavioural sum, and the overflow against a sign-only reference. A design that ties one flag to the other fails. So does a design that takes the overflow from the wrong carry.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GRP_W_DEF = 4;

  typedef struct packed {
    logic prop;
    logic gen;
  } pg_t;
endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic p_o,
  output logic g_o
);
  assign p_o = a_i ^ b_i;
  assign g_o = a_i & b_i;
  assign s_o = p_o ^ c_i;
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  output logic [N-1:0] s_o,
  output logic [N-1:0] p_o,
  output logic [N-1:0] g_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    cla_bit_cell u_cell (
      .a_i(a_i[k]),
      .b_i(b_i[k]),
      .c_i(c_i[k]),
      .s_o(s_o[k]),
      .p_o(p_o[k]),
      .g_o(g_o[k])
    );
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] g_i,
  input  logic         cin_i,
  output logic [N-1:0] cout_o,
  output cla_pkg::pg_t blk_o
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic term;
      term = cin_i;
      for (int k = 0; k <= i; k++) term = term & p_i[k];
      for (int j = 0; j <= i; j++) begin
        logic prod;
        prod = g_i[j];
        for (int k = j + 1; k <= i; k++) prod = prod & p_i[k];
        term = term | prod;
      end
      cout_o[i] = term;
    end
  end

  always_comb begin
    blk_o.prop = &p_i;
    blk_o.gen  = 1'b0;
    for (int j = 0; j < N; j++) begin
      logic prod;
      prod = g_i[j];
      for (int k = j + 1; k < N; k++) prod = prod & p_i[k];
      blk_o.gen = blk_o.gen | prod;
    end
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int unsigned GRP_W = cla_pkg::GRP_W_DEF,
  localparam int unsigned WIDTH = GRP_W * GRP_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int unsigned NGRP = GRP_W;

  cla_pkg::pg_t [NGRP-1:0]  grp_pg;
  logic [NGRP-1:0]          grp_prop, grp_gen;
  logic [NGRP-1:0]          grp_cin;
  logic [NGRP-1:0]          top_carry;
  logic [NGRP-1:0]          grp_last;
  logic [WIDTH-1:0]         bit_p, bit_g, bit_cin;
  cla_pkg::pg_t             top_pg;
  logic                     unused_sink;

  for (genvar grp = 0; grp < NGRP; grp++) begin : g_grp
    logic [GRP_W-1:0] lc;

    cla_slice #(.N(GRP_W)) u_slice (
      .a_i(a_i[grp*GRP_W +: GRP_W]),
      .b_i(b_i[grp*GRP_W +: GRP_W]),
      .c_i(bit_cin[grp*GRP_W +: GRP_W]),
      .s_o(sum_o[grp*GRP_W +: GRP_W]),
      .p_o(bit_p[grp*GRP_W +: GRP_W]),
      .g_o(bit_g[grp*GRP_W +: GRP_W])
    );

    cla_lookahead #(.N(GRP_W)) u_la (
      .p_i(bit_p[grp*GRP_W +: GRP_W]),
      .g_i(bit_g[grp*GRP_W +: GRP_W]),
      .cin_i(grp_cin[grp]),
      .cout_o(lc),
      .blk_o(grp_pg[grp])
    );

    assign bit_cin[grp*GRP_W +: GRP_W] = {lc[GRP_W-2:0], grp_cin[grp]};
    assign grp_last[grp] = lc[GRP_W-1];
    assign grp_prop[grp] = grp_pg[grp].prop;
    assign grp_gen[grp]  = grp_pg[grp].gen;
  end

  cla_lookahead #(.N(NGRP)) u_la_top (
    .p_i(grp_prop),
    .g_i(grp_gen),
    .cin_i(cin_i),
    .cout_o(top_carry),
    .blk_o(top_pg)
  );

  assign grp_cin = {top_carry[NGRP-2:0], cin_i};
  assign cout_o  = top_carry[NGRP-1];
  assign ovf_o   = bit_cin[WIDTH-1] ^ cout_o;

  assign unused_sink = ^{top_pg, grp_last};
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             ovf_o
);
  logic [WIDTH:0] wide;
  assign wide = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    assert_sum_R1: assert (sum_o == wide[WIDTH-1:0])
      else $error("R1 sum mismatch");
    assert_carry_R2: assert (cout_o == wide[WIDTH])
      else $error("R2 carry mismatch");
    assert_no_overflow_R3: assert (!(ovf_o && (a_i[WIDTH-1] != b_i[WIDTH-1])))
      else $error("R3 overflow with mixed signs");
    assert_ovf_sign_R3: assert (ovf_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1])))
      else $error("R3 overflow mismatch");
    assert_propagate_R4: assert (!((a_i == ~b_i) && !((sum_o == {WIDTH{~cin_i}}) && (cout_o == cin_i))))
      else $error("R4 full propagate mismatch");
  end
endmodule

bind cla16_adder cla16_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i),
  .b_i(b_i),
  .cin_i(cin_i),
  .sum_o(sum_o),
  .cout_o(cout_o),
  .ovf_o(ovf_o)
);

// File: tb/test_cla16_adder.sv
`timescale 1ns/1ps
module test_cla16_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a, b;
  logic        cin;
  logic [15:0] sum;
  logic        cout, ovf;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cla16_adder i_cla16_adder (
    .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  function automatic logic [17:0] ref_add(logic [15:0] x, logic [15:0] y, logic c);
    logic [16:0] w;
    logic        v;
    w = {1'b0, x} + {1'b0, y} + {16'd0, c};
    v = (x[15] == y[15]) && (w[15] != x[15]);
    return {v, w};
  endfunction

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c, input string tag);
    logic [17:0] exp;
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    exp = ref_add(x, y, c);
    n_run++;
    if ({ovf, cout, sum} !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%0d: got ovf=%0d cout=%0d sum=%h, expected ovf=%0d cout=%0d sum=%h",
               tag, x, y, c, ovf, cout, sum, exp[17], exp[16], exp[15:0]);
    end
  endtask

  task automatic expect_fixed(input logic [15:0] x, input logic [15:0] y, input logic c,
                              input logic [15:0] es, input logic ec, input logic ev, input string tag);
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    n_run++;
    if (sum !== es || cout !== ec || ovf !== ev) begin
      n_fail++;
      $display("FAIL %s: got sum=%h cout=%0d ovf=%0d, expected sum=%h cout=%0d ovf=%0d",
               tag, sum, cout, ovf, es, ec, ev);
    end
  endtask

  task automatic swap_check(input logic [15:0] x, input logic [15:0] y, input logic c);
    logic [17:0] first;
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    first = {ovf, cout, sum};
    @(posedge clk);
    a = y; b = x;
    @(negedge clk);
    n_run++;
    if ({ovf, cout, sum} !== first) begin
      n_fail++;
      $display("FAIL R7 swap a=%h b=%h: got %h, expected %h", x, y, {ovf, cout, sum}, first);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c1a));
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R6: zero operands, also the idle state after reset
    expect_fixed(16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, "R6 zero cin0");
    expect_fixed(16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0, 1'b0, "R6 zero cin1");

    // R5: long propagate chains
    expect_fixed(16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0, "R5 ffff+1");
    expect_fixed(16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0, 1'b1, "R5 7fff+1");
    expect_fixed(16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, "R5 ffff+cin");

    // R4: every bit propagates
    expect_fixed(16'hA5C3, 16'h5A3C, 1'b0, 16'hFFFF, 1'b0, 1'b0, "R4 prop cin0");
    expect_fixed(16'hA5C3, 16'h5A3C, 1'b1, 16'h0000, 1'b1, 1'b0, "R4 prop cin1");
    expect_fixed(16'h0000, 16'hFFFF, 1'b1, 16'h0000, 1'b1, 1'b0, "R4 prop zero-ones");

    // R2/R3: carry-out and overflow together
    expect_fixed(16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b1, "R2 R3 both flags");
    expect_fixed(16'h8000, 16'h7FFF, 1'b1, 16'h0000, 1'b1, 1'b0, "R3 mixed signs");

    // R1/R2/R3: exhaustive low nibbles, two upper contexts
    for (int ctx = 0; ctx < 2; ctx++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++)
            apply({(ctx != 0) ? 12'hFFF : 12'h000, x[3:0]},
                  {(ctx != 0) ? 12'h7FF : 12'h000, y[3:0]}, c[0], "R1 R2 R3 low nibble");

    // R1/R2/R3: group-boundary carries
    for (int g = 0; g < 4; g++) begin
      logic [15:0] m;
      m = 16'h000F << (4 * g);
      apply(m, 16'h0001 << (4 * g), 1'b0, "R1 R2 group boundary");
      apply(m, 16'h0000, 1'b1, "R1 R2 group boundary cin");
    end

    // R1/R2/R3 random, R7 swap
    for (int n = 0; n < 3000; n++) begin
      apply($urandom_range(16'hFFFF, 0), $urandom_range(16'hFFFF, 0), $urandom_range(1, 0), "R1 R2 R3 random");
    end
    for (int n = 0; n < 200; n++) begin
      swap_check($urandom_range(16'hFFFF, 0), $urandom_range(16'hFFFF, 0), $urandom_range(1, 0));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule